// File: doc/BRIEF.md
# Scanline Playfield Bit Serializer

This block draws a coarse background pattern on one raster line. It runs at the pixel clock and keeps a horizontal position counter. The line starts with a dark blanking interval. After that, twenty pattern bits are shifted out across the left half of the visible line and twenty more across the right half, and each bit is held for four pixel clocks. The bits come from three byte-wide pattern registers that a host CPU writes. The first register supplies four bits and the other two supply eight bits each.

The block does not copy the registers into a line buffer. Each bit is read from its register at the moment it is drawn. A host that rewrites a register after its left-half bits have been shown, but before its right-half bits begin, therefore gets a picture whose two halves differ. A write takes effect at a CPU-bus-cycle boundary, and one bus cycle is three pixel clocks. This latency fixes the exact pixel at which a new value first appears. The `reflect` input chooses how the right half is built. With `reflect` low, the right half repeats the left-half order. With `reflect` high, the right half is the left-half sequence mirrored.

The control is a three-state line machine. State names and transitions:
- ST_HBLANK moves to ST_LEFT on the clock after position 67.
- ST_LEFT moves to ST_RIGHT after position 147.
- ST_RIGHT moves back to ST_HBLANK after position 227.

Top module: `pf_line_serializer`

## Requirements
- R1: While `rst_n` is low, `hpos` is 0 and `pf_on` is 0. All three pattern registers reset to 0x00, so the first line after reset is entirely dark.
- R2: `hpos` advances by one on every clock and wraps from 227 back to 0.
- R3: `pf_on` is 0 for every position from 0 to 67, whatever the register contents.
- R4: For positions 68 to 147, bit index k = (hpos-68)/4 selects the output. Indices 0-3 show register 0 bits 4,5,6,7. Indices 4-11 show register 1 bits 7 down to 0. Indices 12-19 show register 2 bits 0 up to 7.
- R5: With `reflect` = 0, positions 148 to 227 use k = (hpos-148)/4 with the same mapping as R4.
- R6: With `reflect` = 1, positions 148 to 227 use index 19-k. The right half therefore shows register 2 bits 7..0, then register 1 bits 0..7, then register 0 bits 7..4, and register 2 is drawn twice in a row across the centre.
- R7: The CPU phase is hpos mod 3. A write strobe sampled at a clock edge while `hpos` = h changes the output first at the position that is the next multiple of 3 above h. `wr_sel` 0, 1 and 2 address registers 0, 1 and 2. `wr_sel` = 3 changes nothing.
- R8: The output reads register contents live. If a write lands after a register's left-half bits end and before its right-half bits start, only the right half changes.
- R9: Bits 3..0 of register 0 never reach the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one clock per write |
| wr_sel | input | 2 | Pattern register select (0..2; 3 is ignored) |
| wr_data | input | 8 | Write data |
| reflect | input | 1 | 1 = mirrored right half, 0 = repeated right half |
| pf_on | output | 1 | Playfield pixel active at the current position |
| hpos | output | 8 | Horizontal pixel position, 0..227 |

## Verification
The embedded assertions check invariants on every cycle:
- the counter steps by one and wraps at the line end;
- the CPU phase stays locked to the position;
- the output is dark in blanking;
- the line state agrees with the position;
- a pattern register can change only at a CPU-cycle boundary.

Only the directed scenarios can show the bit ordering in each half under both modes, the exact pixel at which a write first appears, and a right-half-only change caused by a mid-line rewrite. To check these, the bench compares every pixel of each line against an independent model of the register contents at that pixel.

// File: rtl/pf_pkg.sv
package pf_pkg;

    // Line segment the serializer is currently in
    typedef enum logic [1:0] {
        ST_HBLANK = 2'd0,
        ST_LEFT   = 2'd1,
        ST_RIGHT  = 2'd2
    } line_state_t;

    // Geometry defaults shared by the modules
    localparam int PF_LINE_CLKS   = 228;
    localparam int PF_HBLANK_CLKS = 68;
    localparam int PF_CPU_DIV     = 3;
    localparam int PF_BIT_CLKS    = 4;
    localparam int PF_SEG0_BITS   = 4;
    localparam int PF_SEG1_BITS   = 8;
    localparam int PF_SEG2_BITS   = 8;

endpackage

// File: rtl/pf_hcount.sv
// Horizontal pixel counter plus the CPU-cycle phase divider.
module pf_hcount #(
    parameter int LINE_CLKS = pf_pkg::PF_LINE_CLKS,
    parameter int CPU_DIV   = pf_pkg::PF_CPU_DIV,
    parameter int HW        = $clog2(LINE_CLKS),
    parameter int PW        = (CPU_DIV > 2) ? $clog2(CPU_DIV) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] hpos,
    output logic [PW-1:0] phase,
    output logic          cpu_last
);

    localparam logic [HW-1:0] HPOS_LAST  = HW'(LINE_CLKS - 1);
    localparam logic [PW-1:0] PHASE_LAST = PW'(CPU_DIV - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hpos <= '0;
        end else if (hpos == HPOS_LAST) begin
            hpos <= '0;
        end else begin
            hpos <= hpos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (phase == PHASE_LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign cpu_last = (phase == PHASE_LAST);

    // R2: line counter wraps at the end of the line
    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (hpos == HPOS_LAST) |=> (hpos == '0));

    // R2: line counter steps by one elsewhere
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (hpos != HPOS_LAST) |=> (hpos == $past(hpos) + 1'b1));

    // R7: CPU phase stays locked to hpos mod CPU_DIV
    a_r7_phase_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(phase) == (32'(hpos) % CPU_DIV)));

endmodule

// File: rtl/pf_regs.sv
// Pattern registers with bus-cycle write latency: a strobe is held
// until the last pixel clock of its CPU cycle and committed there.
module pf_regs #(
    parameter int NREG  = 3,
    parameter int W     = 8,
    parameter int SEL_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_last,
    input  logic                    wr_en,
    input  logic [SEL_W-1:0]        wr_sel,
    input  logic [W-1:0]            wr_data,
    output logic [NREG-1:0][W-1:0]  regs
);

    logic             pend_vld;
    logic [SEL_W-1:0] pend_sel;
    logic [W-1:0]     pend_data;

    // Strobes that do not fall on a boundary wait here
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vld  <= 1'b0;
            pend_sel  <= '0;
            pend_data <= '0;
        end else if (wr_en && !cpu_last) begin
            pend_vld  <= 1'b1;
            pend_sel  <= wr_sel;
            pend_data <= wr_data;
        end else if (cpu_last) begin
            pend_vld  <= 1'b0;
        end
    end

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (wr_en && cpu_last && (wr_sel == SEL_W'(i))) begin
                regs[i] <= wr_data;
            end else if (cpu_last && pend_vld && (pend_sel == SEL_W'(i))) begin
                regs[i] <= pend_data;
            end
        end
    end

    // R7: register contents change only at a CPU-cycle boundary
    a_r7_commit_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs) |-> $past(cpu_last));

endmodule

// File: rtl/pf_bitsel.sv
// Maps a bit index in a half line to a pattern register bit.
module pf_bitsel #(
    parameter int W     = 8,
    parameter int SEG0  = pf_pkg::PF_SEG0_BITS,
    parameter int SEG1  = pf_pkg::PF_SEG1_BITS,
    parameter int SEG2  = pf_pkg::PF_SEG2_BITS,
    parameter int TOTAL = SEG0 + SEG1 + SEG2,
    parameter int IW    = $clog2(TOTAL)
) (
    input  logic [W-1:0]  r0,
    input  logic [W-1:0]  r1,
    input  logic [W-1:0]  r2,
    input  logic [IW-1:0] idx,
    input  logic          mirror,
    output logic          bit_out
);

    localparam logic [IW-1:0] IDX_LAST = IW'(TOTAL - 1);

    logic [TOTAL-1:0] seq;
    logic [IW-1:0]    eff;

    // First register: upper bits only, ascending
    for (genvar k = 0; k < SEG0; k++) begin : g_seg0
        assign seq[k] = r0[W - SEG0 + k];
    end
    // Second register: descending from the top bit
    for (genvar k = 0; k < SEG1; k++) begin : g_seg1
        assign seq[SEG0 + k] = r1[W - 1 - k];
    end
    // Third register: ascending from bit 0
    for (genvar k = 0; k < SEG2; k++) begin : g_seg2
        assign seq[SEG0 + SEG1 + k] = r2[k];
    end

    assign eff     = mirror ? (IDX_LAST - idx) : idx;
    assign bit_out = (eff <= IDX_LAST) ? seq[eff] : 1'b0;

endmodule

// File: rtl/pf_line_serializer.sv
module pf_line_serializer #(
    parameter int DATA_W      = 8,
    parameter int LINE_CLKS   = pf_pkg::PF_LINE_CLKS,
    parameter int HBLANK_CLKS = pf_pkg::PF_HBLANK_CLKS,
    parameter int CPU_DIV     = pf_pkg::PF_CPU_DIV,
    parameter int BIT_CLKS    = pf_pkg::PF_BIT_CLKS,
    localparam int HPOS_W     = $clog2(LINE_CLKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              reflect,
    output logic              pf_on,
    output logic [HPOS_W-1:0] hpos
);
    import pf_pkg::*;

    localparam int HALF_BITS = PF_SEG0_BITS + PF_SEG1_BITS + PF_SEG2_BITS;
    localparam int HALF_CLKS = HALF_BITS * BIT_CLKS;
    localparam int IW        = $clog2(HALF_BITS);
    localparam int PW        = (CPU_DIV > 2) ? $clog2(CPU_DIV) : 1;
    localparam logic [HPOS_W-1:0] LEFT_START  = HPOS_W'(HBLANK_CLKS);
    localparam logic [HPOS_W-1:0] RIGHT_START = HPOS_W'(HBLANK_CLKS + HALF_CLKS);
    localparam logic [HPOS_W-1:0] HPOS_LAST   = HPOS_W'(LINE_CLKS - 1);

    logic [PW-1:0]          phase;
    logic                   cpu_last;
    logic [2:0][DATA_W-1:0] regs;
    line_state_t            state, nxt;
    logic [HPOS_W-1:0]      off;
    logic [IW-1:0]          idx;
    logic                   right, vis, pat_bit;

    pf_hcount #(.LINE_CLKS(LINE_CLKS), .CPU_DIV(CPU_DIV), .HW(HPOS_W), .PW(PW)) u_hcount (
        .clk      (clk),
        .rst_n    (rst_n),
        .hpos     (hpos),
        .phase    (phase),
        .cpu_last (cpu_last)
    );

    pf_regs #(.NREG(3), .W(DATA_W), .SEL_W(2)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_last (cpu_last),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .regs     (regs)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HBLANK;
        else        state <= nxt;
    end

    // Transitions follow the position counter
    always_comb begin
        nxt = state;
        unique case (state)
            ST_HBLANK: if (hpos == LEFT_START - 1'b1)  nxt = ST_LEFT;
            ST_LEFT:   if (hpos == RIGHT_START - 1'b1) nxt = ST_RIGHT;
            ST_RIGHT:  if (hpos == HPOS_LAST)          nxt = ST_HBLANK;
            default:   nxt = ST_HBLANK;
        endcase
    end

    // Outputs per state
    always_comb begin
        off   = '0;
        right = 1'b0;
        vis   = 1'b0;
        unique case (state)
            ST_HBLANK: begin
                vis = 1'b0;
            end
            ST_LEFT: begin
                off = hpos - LEFT_START;
                vis = 1'b1;
            end
            ST_RIGHT: begin
                off   = hpos - RIGHT_START;
                right = 1'b1;
                vis   = 1'b1;
            end
            default: vis = 1'b0;
        endcase
    end

    assign idx = IW'(off / HPOS_W'(BIT_CLKS));

    pf_bitsel #(.W(DATA_W)) u_bitsel (
        .r0      (regs[0]),
        .r1      (regs[1]),
        .r2      (regs[2]),
        .idx     (idx),
        .mirror  (right && reflect),
        .bit_out (pat_bit)
    );

    assign pf_on = vis && pat_bit;

    // R3: dark through horizontal blank
    a_r3_blank_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (hpos < LEFT_START) |-> !pf_on);

    // R4: left state only inside the left window
    a_r4_left_align: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LEFT) |-> (hpos >= LEFT_START && hpos < RIGHT_START));

    // R5: right state only inside the right window
    a_r5_right_align: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RIGHT) |-> (hpos >= RIGHT_START));

    // R2: the line end always returns the machine to blanking
    a_r2_line_end: assert property (@(posedge clk) disable iff (!rst_n)
        (hpos == HPOS_LAST) |=> (state == ST_HBLANK));

endmodule

// File: tb/pf_line_serializer_tb.sv
module pf_line_serializer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       reflect = 1'b0;
    logic       pf_on;
    logic [7:0] hpos;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pf_line_serializer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .reflect(reflect), .pf_on(pf_on), .hpos(hpos)
    );

    // Independent reference of one pixel
    function automatic logic ref_pix(int p, logic [7:0] a, logic [7:0] b,
                                     logic [7:0] c, logic mir);
        int pix, k;
        if (p < 68) return 1'b0;
        pix = p - 68;
        k = (pix % 80) / 4;
        if (pix >= 80 && mir) k = 19 - k;
        if (k < 4)  return a[4 + k];
        if (k < 12) return b[7 - (k - 4)];
        return c[k - 12];
    endfunction

    task automatic check(string tag, int act, int exp, int p);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s hpos=%0d actual=%0d expected=%0d", tag, p, act, exp);
        end
    endtask

    // Write one register at the next negedge, one clock long
    task automatic host_write(logic [1:0] s, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_all(logic [7:0] a, logic [7:0] b, logic [7:0] c);
        host_write(2'd0, a);
        host_write(2'd1, b);
        host_write(2'd2, c);
    endtask

    // Run one full line, optional write at position wh, compare every pixel
    task automatic run_line(string tag, logic [7:0] a, logic [7:0] b, logic [7:0] c,
                            logic mir, bit do_wr, logic [1:0] ws, logic [7:0] wv, int wh);
        int eff;
        logic [7:0] na, nb, nc;
        na = a; nb = b; nc = c;
        if (do_wr && ws == 2'd0) na = wv;
        if (do_wr && ws == 2'd1) nb = wv;
        if (do_wr && ws == 2'd2) nc = wv;
        eff = (wh / 3 + 1) * 3;
        reflect = mir;
        while (hpos != 8'd0) @(negedge clk);
        for (int i = 0; i < 228; i++) begin
            logic e;
            wr_en   = do_wr && (i == wh);
            wr_sel  = ws;
            wr_data = wv;
            check("R2", int'(hpos), i, i);
            if (do_wr && i >= eff) e = ref_pix(i, na, nb, nc, mir);
            else                   e = ref_pix(i, a, b, c, mir);
            check((i < 68) ? "R3" : tag, int'(pf_on), int'(e), i);
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check("R1", int'(hpos), 0, 0);
        check("R1", int'(pf_on), 0, 0);
        rst_n = 1'b1;
        run_line("R1", 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 2'd0, 8'h00, 0);
    endtask

    task automatic t_repeat;
        load_all(8'hA0, 8'h96, 8'h3C);
        run_line("R4_R5", 8'hA0, 8'h96, 8'h3C, 1'b0, 1'b0, 2'd0, 8'h00, 0);
    endtask

    task automatic t_reflect;
        load_all(8'h50, 8'hC1, 8'h8E);
        run_line("R6", 8'h50, 8'hC1, 8'h8E, 1'b1, 1'b0, 2'd0, 8'h00, 0);
    endtask

    task automatic t_low_nibble;
        load_all(8'h5F, 8'h00, 8'h00);
        run_line("R9", 8'h5F, 8'h00, 8'h00, 1'b0, 1'b0, 2'd0, 8'h00, 0);
    endtask

    task automatic t_mid_write_right_only;
        load_all(8'hF0, 8'hFF, 8'h00);
        // lands at 117: left bits of reg1 ended at 115, right starts 164
        run_line("R8", 8'hF0, 8'hFF, 8'h00, 1'b0, 1'b1, 2'd1, 8'h0F, 114);
    endtask

    task automatic t_early_write_both;
        load_all(8'h00, 8'hFF, 8'h00);
        // lands at 81, before reg1 left bits at 84: both halves change
        run_line("R7", 8'h00, 8'hFF, 8'h00, 1'b0, 1'b1, 2'd1, 8'hAA, 80);
    endtask

    task automatic t_latency_edge;
        load_all(8'h00, 8'h00, 8'h00);
        // strobe at 113 (phase 2) becomes visible at 114, mid last bit
        run_line("R7", 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 2'd1, 8'h01, 113);
    endtask

    task automatic t_reflect_late_reg0;
        load_all(8'hF0, 8'h00, 8'h00);
        // reflect: reg0 right copy drawn from 212, so a write at 200 is right-only
        run_line("R6_R8", 8'hF0, 8'h00, 8'h00, 1'b1, 1'b1, 2'd0, 8'h30, 200);
    endtask

    task automatic t_bad_select;
        load_all(8'h90, 8'h5A, 8'hC3);
        // wr_sel 3 addresses nothing
        run_line("R7", 8'h90, 8'h5A, 8'hC3, 1'b0, 1'b1, 2'd3, 8'hFF, 90);
        run_line("R7", 8'h90, 8'h5A, 8'hC3, 1'b1, 1'b0, 2'd0, 8'h00, 0);
    endtask

    initial begin
        t_reset;
        t_repeat;
        t_reflect;
        t_low_nibble;
        t_mid_write_right_only;
        t_early_write_both;
        t_latency_edge;
        t_reflect_late_reg0;
        t_bad_select;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule